// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block sits beside a small microcontroller core and decides when the core may run. It produces a cold reset and a warm reset. It also drives a run enable that gates the core clock. When the core comes out of HALT, it pulses one of two resume decisions: enter the interrupt handler, or continue at the next instruction. It keeps two status bits, a time-out bit and a power-down bit. Software reads these bits to tell which event caused the last restart.

A power-on reset and every exit from HALT hold the core for a fixed start-up window of `DLY` clocks, 1024 by default, while the oscillator settles. The block accepts several wake sources while halted:

- a port pin whose own enable bit is set;
- an interrupt request that was not already pending when HALT began;
- a watchdog time-out;
- the external reset pin.

A watchdog time-out while halted gives a warm reset, which restarts only the program counter and stack pointer. The external reset pin is active-low. It asserts asynchronously and is released through a two-flop synchroniser.

Top module: `wake_reset_seq`

## Requirements
- R1: While `por` is high, `cold_rst`=1, `core_run`=0, `flag_to`=0 and `flag_pdf`=0. After `por` falls, `core_run` stays 0 for exactly 1023 further clocks and becomes 1 on the 1024th, with no resume pulse.
- R2: A `halt_req` seen while running, with no watchdog time-out or external reset, stops `core_run` on the next clock. It sets `flag_pdf`=1 and leaves `flag_to` unchanged.
- R3: In HALT, any bit set in `port_pin & port_wake_en` wakes the block. After the start-up delay (1024 clocks counted from the wake clock), `core_run`=1 together with a one-clock `resume_next` pulse. A pin whose enable is 0 has no effect.
- R4: In HALT, a new interrupt request on a line whose `irq_en` bit is 1, while `stack_full`=0, wakes the block. After the delay it gives a one-clock `take_irq` pulse.
- R5: A new interrupt request whose enable is 0, or one that arrives while `stack_full`=1, still wakes the block. It ends with `resume_next` instead of `take_irq`.
- R6: Interrupt lines already high on the clock that HALT is entered do not wake the block.
- R7: A watchdog time-out in HALT sets `flag_to`=1 and `flag_pdf`=1. It holds `warm_rst`=1 and `cold_rst`=0 for the start-up delay, then runs with neither resume pulse.
- R8: A watchdog time-out while running gives a one-clock `cold_rst` with `core_run`=0. It sets `flag_to`=1 and leaves `flag_pdf` unchanged.
- R9: `ext_rst_n` low while running raises `cold_rst` on the next clock and leaves both flags unchanged. After release, `cold_rst` stays high for two more clocks, and the core then runs with no start-up delay.
- R10: `ext_rst_n` low in HALT sets `flag_to`=0 and `flag_pdf`=1. It holds `cold_rst` for the start-up delay, after which the core runs with no resume pulse.
- R11: Wake sources that stay active, or that reappear, during the start-up delay neither restart nor lengthen it.
- R12: When a watchdog time-out and an enabled port wake occur in the same HALT clock, the watchdog wins: warm reset, then no resume pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active-high |
| ext_rst_n | input | 1 | External reset pin, active-low, asynchronous assert |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| port_pin | input | NPIN | Port pin levels |
| port_wake_en | input | NPIN | Per-pin wake enable |
| irq_req | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Per-line interrupt enable |
| stack_full | input | 1 | Core return stack is full |
| halt_req | input | 1 | Core requests HALT |
| core_run | output | 1 | Core clock enable |
| cold_rst | output | 1 | Full-chip reset to the core |
| warm_rst | output | 1 | Reset of program counter and stack pointer only |
| take_irq | output | 1 | One-clock pulse: enter interrupt handler on resume |
| resume_next | output | 1 | One-clock pulse: continue at next instruction on resume |
| flag_to | output | 1 | Time-out status bit |
| flag_pdf | output | 1 | Power-down status bit |

## Verification
The functions that can collide are the watchdog restart and the port-pin wake. Both are legal in the same halted clock, and they lead to different endings. The bench raises `wdt_timeout` and an enabled port pin on the same clock during HALT. It expects `warm_rst` in place of a plain delay, `flag_to`=1, and no `resume_next` once the core runs. The enabled pin stays high through the whole window, which also shows that the delay count does not restart.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        ST_DELAY   = 2'd0,
        ST_RUN     = 2'd1,
        ST_HALT    = 2'd2,
        ST_RSTHOLD = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        WK_NONE     = 3'd0,
        WK_POR      = 3'd1,
        WK_EXT      = 3'd2,
        WK_WDT      = 3'd3,
        WK_PORT     = 3'd4,
        WK_IRQ_TAKE = 3'd5,
        WK_IRQ_NEXT = 3'd6
    } wake_cause_e;

    typedef struct packed {
        logic to;
        logic pdf;
    } stat_flags_t;

    // causes whose start-up window also holds the whole chip in reset
    function automatic logic cause_is_cold(wake_cause_e c);
        return (c == WK_POR) || (c == WK_EXT);
    endfunction

    // causes that continue at the following instruction
    function automatic logic cause_resumes(wake_cause_e c);
        return (c == WK_PORT) || (c == WK_IRQ_NEXT);
    endfunction

endpackage

// File: rtl/rsq_reset_sync.sv
module rsq_reset_sync (
    input  logic clk,
    input  logic pin_n,
    output logic rst_act
);
    logic q1, q2;

    // asserts at once with the pin, releases after two clean edges
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            q1 <= 1'b0;
            q2 <= 1'b0;
        end else begin
            q1 <= 1'b1;
            q2 <= q1;
        end
    end

    assign rst_act = ~q2;
endmodule

// File: rtl/rsq_startup_timer.sv
module rsq_startup_timer #(
    parameter int DLY = 1024,
    parameter int CW  = $clog2(DLY) + 1
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    output logic done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = en && (cnt_q == CW'(DLY - 1));
endmodule

// File: rtl/rsq_wake_detect.sv
module rsq_wake_detect #(
    parameter int NPIN = 8,
    parameter int NIRQ = 4
) (
    input  logic [NPIN-1:0] port_pin,
    input  logic [NPIN-1:0] port_wake_en,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_stale,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            stack_full,
    output logic            port_hit,
    output logic            irq_hit,
    output logic            irq_take
);
    logic [NIRQ-1:0] irq_fresh;

    assign port_hit  = |(port_pin & port_wake_en);
    assign irq_fresh = irq_req & ~irq_stale;
    assign irq_hit   = |irq_fresh;
    assign irq_take  = (|(irq_fresh & irq_en)) && !stack_full;
endmodule

// File: rtl/wake_reset_seq.sv
module wake_reset_seq
    import rsq_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int NIRQ = 4,
    parameter int DLY  = 1024
) (
    input  logic            clk,
    input  logic            por,
    input  logic            ext_rst_n,
    input  logic            wdt_timeout,
    input  logic [NPIN-1:0] port_pin,
    input  logic [NPIN-1:0] port_wake_en,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            stack_full,
    input  logic            halt_req,
    output logic            core_run,
    output logic            cold_rst,
    output logic            warm_rst,
    output logic            take_irq,
    output logic            resume_next,
    output logic            flag_to,
    output logic            flag_pdf
);
    localparam int CW = $clog2(DLY) + 1;

    seq_state_e      state_q, state_d;
    wake_cause_e     cause_q, cause_d;
    stat_flags_t     flg_q, flg_d;
    logic [NIRQ-1:0] stale_q, stale_d;
    logic            take_q, take_d, next_q, next_d;
    logic            enter_delay, ext_act, dly_done;
    logic            port_hit, irq_hit, irq_take;
    logic            halted;

    rsq_reset_sync u_sync (
        .clk     (clk),
        .pin_n   (ext_rst_n),
        .rst_act (ext_act)
    );

    rsq_startup_timer #(.DLY(DLY), .CW(CW)) u_timer (
        .clk  (clk),
        .clr  (por || enter_delay),
        .en   (state_q == ST_DELAY),
        .done (dly_done)
    );

    rsq_wake_detect #(.NPIN(NPIN), .NIRQ(NIRQ)) u_wake (
        .port_pin     (port_pin),
        .port_wake_en (port_wake_en),
        .irq_req      (irq_req),
        .irq_stale    (stale_q),
        .irq_en       (irq_en),
        .stack_full   (stack_full),
        .port_hit     (port_hit),
        .irq_hit      (irq_hit),
        .irq_take     (irq_take)
    );

    always_comb begin
        state_d     = state_q;
        cause_d     = cause_q;
        flg_d       = flg_q;
        stale_d     = stale_q;
        take_d      = 1'b0;
        next_d      = 1'b0;
        enter_delay = 1'b0;
        if (state_q == ST_DELAY) begin
            // window runs to its end whatever else is active
            if (dly_done) begin
                state_d = ST_RUN;
                take_d  = (cause_q == WK_IRQ_TAKE);
                next_d  = cause_resumes(cause_q);
            end
        end else if (ext_act) begin
            if (state_q == ST_HALT) begin
                flg_d       = '{to: 1'b0, pdf: 1'b1};
                cause_d     = WK_EXT;
                state_d     = ST_DELAY;
                enter_delay = 1'b1;
            end else begin
                state_d = ST_RSTHOLD;
            end
        end else begin
            unique case (state_q)
                ST_RSTHOLD: state_d = ST_RUN;
                ST_RUN: begin
                    if (wdt_timeout) begin
                        flg_d.to = 1'b1;
                        state_d  = ST_RSTHOLD;
                    end else if (halt_req) begin
                        flg_d.pdf = 1'b1;
                        stale_d   = irq_req;
                        state_d   = ST_HALT;
                    end
                end
                ST_HALT: begin
                    if (wdt_timeout) begin
                        flg_d       = '{to: 1'b1, pdf: 1'b1};
                        cause_d     = WK_WDT;
                        state_d     = ST_DELAY;
                        enter_delay = 1'b1;
                    end else if (port_hit) begin
                        cause_d     = WK_PORT;
                        state_d     = ST_DELAY;
                        enter_delay = 1'b1;
                    end else if (irq_hit) begin
                        cause_d     = irq_take ? WK_IRQ_TAKE : WK_IRQ_NEXT;
                        state_d     = ST_DELAY;
                        enter_delay = 1'b1;
                    end
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= ST_DELAY;
            cause_q <= WK_POR;
            flg_q   <= '0;
            stale_q <= '0;
            take_q  <= 1'b0;
            next_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            flg_q   <= flg_d;
            stale_q <= stale_d;
            take_q  <= take_d;
            next_q  <= next_d;
        end
    end

    assign halted      = (state_q == ST_HALT);
    assign core_run    = (state_q == ST_RUN);
    assign cold_rst    = (state_q == ST_RSTHOLD) ||
                         ((state_q == ST_DELAY) && cause_is_cold(cause_q));
    assign warm_rst    = (state_q == ST_DELAY) && (cause_q == WK_WDT);
    assign take_irq    = take_q;
    assign resume_next = next_q;
    assign flag_to     = flg_q.to;
    assign flag_pdf    = flg_q.pdf;
endmodule

// File: rtl/wake_reset_seq_chk.sv
module wake_reset_seq_chk #(
    parameter int DLY = 1024
) (
    input logic clk,
    input logic por,
    input logic halt_req,
    input logic wdt_timeout,
    input logic ext_act,
    input logic halted,
    input logic core_run,
    input logic cold_rst,
    input logic warm_rst,
    input logic take_irq,
    input logic resume_next,
    input logic flag_to,
    input logic flag_pdf
);
    localparam int KW = $clog2(DLY) + 2;
    logic [KW-1:0] win_cnt;

    // length of an unbroken reset window with the pin released
    always_ff @(posedge clk) begin
        if (por || !((cold_rst || warm_rst) && !ext_act))
            win_cnt <= '0;
        else
            win_cnt <= win_cnt + 1'b1;
    end

    p_halt_enter_r2: assert property (@(posedge clk) disable iff (por)
        (core_run && halt_req && !wdt_timeout && !ext_act) |=> (!core_run && halted && flag_pdf));

    p_pulse_first_r3: assert property (@(posedge clk) disable iff (por)
        (take_irq || resume_next) |-> (core_run && !$past(core_run)));

    p_pulse_excl_r4: assert property (@(posedge clk) disable iff (por)
        !(take_irq && resume_next));

    p_wdt_halt_r7: assert property (@(posedge clk) disable iff (por)
        (halted && wdt_timeout && !ext_act) |=> (warm_rst && !cold_rst && flag_to && flag_pdf));

    p_wdt_run_r8: assert property (@(posedge clk) disable iff (por)
        (core_run && wdt_timeout && !ext_act) |=> (cold_rst && flag_to && $stable(flag_pdf)));

    p_window_bound_r11: assert property (@(posedge clk) disable iff (por)
        win_cnt <= KW'(DLY));
endmodule

bind wake_reset_seq wake_reset_seq_chk #(.DLY(DLY)) u_chk (
    .clk         (clk),
    .por         (por),
    .halt_req    (halt_req),
    .wdt_timeout (wdt_timeout),
    .ext_act     (ext_act),
    .halted      (halted),
    .core_run    (core_run),
    .cold_rst    (cold_rst),
    .warm_rst    (warm_rst),
    .take_irq    (take_irq),
    .resume_next (resume_next),
    .flag_to     (flag_to),
    .flag_pdf    (flag_pdf)
);

// File: tb/wake_reset_seq_bench.sv
`timescale 1ns/1ps
module wake_reset_seq_bench;
    localparam int NPIN = 8;
    localparam int NIRQ = 4;
    localparam int DLY  = 1024;

    logic clk = 1'b0;
    logic por, ext_rst_n, wdt_timeout, stack_full, halt_req;
    logic [NPIN-1:0] port_pin, port_wake_en;
    logic [NIRQ-1:0] irq_req, irq_en;
    logic core_run, cold_rst, warm_rst, take_irq, resume_next, flag_to, flag_pdf;

    int checks = 0;
    int errs   = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    wake_reset_seq #(.NPIN(NPIN), .NIRQ(NIRQ), .DLY(DLY)) u_wake_reset_seq (
        .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout),
        .port_pin(port_pin), .port_wake_en(port_wake_en), .irq_req(irq_req),
        .irq_en(irq_en), .stack_full(stack_full), .halt_req(halt_req),
        .core_run(core_run), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .take_irq(take_irq), .resume_next(resume_next),
        .flag_to(flag_to), .flag_pdf(flag_pdf)
    );

    // exp: 0 = no wake, 1 = resume next, 2 = take interrupt
    typedef struct packed {
        logic [7:0] pin;
        logic [7:0] pen;
        logic [3:0] irq;
        logic [3:0] ien;
        logic       sf;
        logic [1:0] exp;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{8'h01, 8'h01, 4'h0, 4'h0, 1'b0, 2'd1},
        '{8'h02, 8'h00, 4'h0, 4'h0, 1'b0, 2'd0},
        '{8'h80, 8'h80, 4'h0, 4'h0, 1'b0, 2'd1},
        '{8'h00, 8'h00, 4'h1, 4'h1, 1'b0, 2'd2},
        '{8'h00, 8'h00, 4'h2, 4'h0, 1'b0, 2'd1},
        '{8'h00, 8'h00, 4'h4, 4'h4, 1'b1, 2'd1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // after the step that opened the window: 1023 quiet clocks, run on the next
    task automatic ride_window(string tag);
        repeat (DLY - 1) step();
        chk(tag, "core_run held in window", 32'(core_run), 0);
        step();
        chk(tag, "core_run after window", 32'(core_run), 1);
    endtask

    task automatic enter_halt();
        halt_req = 1'b1;
        step();
        halt_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        string tag;
        por = 1'b1; ext_rst_n = 1'b1; wdt_timeout = 1'b0; stack_full = 1'b0;
        halt_req = 1'b0; port_pin = '0; port_wake_en = '0; irq_req = '0; irq_en = '0;
        repeat (3) step();
        // R1 reset state
        chk("R1", "cold_rst in por", 32'(cold_rst), 1);
        chk("R1", "core_run in por", 32'(core_run), 0);
        chk("R1", "flags in por", {30'd0, flag_to, flag_pdf}, 0);
        por = 1'b0;
        ride_window("R1");
        chk("R1", "cold_rst released", 32'(cold_rst), 0);
        chk("R1", "no resume pulse", {30'd0, take_irq, resume_next}, 0);

        // table of halt wake cases (R3 R4 R5 R11)
        for (int i = 0; i < 6; i++) begin
            tag = (VEC[i].exp == 2'd2) ? "R4" : ((VEC[i].irq != 0) ? "R5" : "R3");
            enter_halt();
            chk("R2", "halt stops core", 32'(core_run), 0);
            chk("R2", "pdf set on halt", 32'(flag_pdf), 1);
            port_pin = VEC[i].pin; port_wake_en = VEC[i].pen;
            irq_req = VEC[i].irq; irq_en = VEC[i].ien; stack_full = VEC[i].sf;
            step();
            if (VEC[i].exp == 2'd0) begin
                repeat (1100) step();
                chk(tag, "disabled pin keeps halt", 32'(core_run), 0);
                port_pin = 8'h01; port_wake_en = 8'h01;
                step();
            end
            // stimulus stays held for the whole window: R11
            ride_window(tag);
            chk(tag, "take_irq pulse", 32'(take_irq), (VEC[i].exp == 2'd2) ? 1 : 0);
            chk(tag, "resume_next pulse", 32'(resume_next), (VEC[i].exp == 2'd2) ? 0 : 1);
            port_pin = '0; port_wake_en = '0; irq_req = '0; irq_en = '0; stack_full = 1'b0;
            step();
            chk(tag, "pulse lasts one clock", {30'd0, take_irq, resume_next}, 0);
        end

        // R6 request pending at halt entry does not wake
        irq_req = 4'h1; irq_en = 4'h3;
        enter_halt();
        repeat (1100) step();
        chk("R6", "pending irq ignored", 32'(core_run), 0);
        irq_req = 4'h3;
        step();
        ride_window("R6");
        chk("R6", "fresh irq taken", 32'(take_irq), 1);
        irq_req = '0; irq_en = '0;
        step();

        // R8 watchdog while running
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk("R8", "cold pulse", 32'(cold_rst), 1);
        chk("R8", "core stopped", 32'(core_run), 0);
        chk("R8", "flags to=1 pdf kept", {30'd0, flag_to, flag_pdf}, 3);
        step();
        chk("R8", "runs again", {30'd0, core_run, cold_rst}, 2);

        // R9 external reset while running
        ext_rst_n = 1'b0;
        step();
        chk("R9", "cold on pin", 32'(cold_rst), 1);
        repeat (3) step();
        ext_rst_n = 1'b1;
        step();
        step();
        chk("R9", "cold held through sync", 32'(cold_rst), 1);
        step();
        chk("R9", "runs without delay", 32'(core_run), 1);
        chk("R9", "flags unchanged", {30'd0, flag_to, flag_pdf}, 3);

        // R10 external reset in halt
        enter_halt();
        ext_rst_n = 1'b0;
        step();
        chk("R10", "cold in window", {30'd0, cold_rst, warm_rst}, 2);
        chk("R10", "flags to=0 pdf=1", {30'd0, flag_to, flag_pdf}, 1);
        ext_rst_n = 1'b1;
        step();
        repeat (DLY - 2) step();
        chk("R10", "core_run held in window", 32'(core_run), 0);
        step();
        chk("R10", "runs after window", 32'(core_run), 1);
        chk("R10", "no resume pulse", {30'd0, take_irq, resume_next}, 0);

        // R7 watchdog in halt
        enter_halt();
        chk("R2", "to kept on halt", 32'(flag_to), 0);
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk("R7", "warm not cold", {30'd0, cold_rst, warm_rst}, 1);
        chk("R7", "flags to=1 pdf=1", {30'd0, flag_to, flag_pdf}, 3);
        ride_window("R7");
        chk("R7", "no resume pulse", {30'd0, take_irq, resume_next}, 0);

        // R12 watchdog and port wake on the same halted clock
        enter_halt();
        wdt_timeout = 1'b1; port_pin = 8'h10; port_wake_en = 8'h10;
        step();
        wdt_timeout = 1'b0;
        chk("R12", "watchdog wins", {30'd0, cold_rst, warm_rst}, 1);
        ride_window("R12");
        chk("R12", "no resume pulse", {30'd0, take_irq, resume_next}, 0);
        port_pin = '0; port_wake_en = '0;
        step();

        finish_run();
    end
endmodule